// File: doc/BRIEF.md
# Host Byte Port for a Signal Processor Data Register

This block sits between an 8-bit host bus and a signal processor core. Through one register-select input the host reaches either a 16-bit data register or the upper byte of a status word. A data transfer can move the whole data register as two bytes, low byte first. It can also move only the low byte, depending on a width mode that the core controls. The block keeps two flags. One is a byte-order flag that says whether the high byte comes next. The other is a pending flag that says a transfer is still owed.

The core has a small register interface. It can load the data register, read it back, raise the pending flag when it has placed a word or wants one, and set the width mode. The host ends a transfer by moving the last byte, which drops the pending flag. The host may also take a debug look at the data register without disturbing the sequencing flags. Host writes to the status location have no effect.

Top module: `hpi_byte_port`

## Requirements
- R1: With `hst_sel` at 1 a host read returns the status byte {pending, high-next, narrow, 5'b00000} (bit 7 = pending, bit 6 = high-next, bit 5 = narrow). Reading it changes no flag. `hst_rdata` is 0 when no read or peek is active.
- R2: A host write with `hst_sel` at 1 changes neither the data register nor any flag.
- R3: In wide mode (narrow = 0), a data read with high-next at 0 returns DR[7:0] and sets high-next. A data read with high-next at 1 returns DR[15:8] and clears both high-next and pending.
- R4: In narrow mode, a data read returns DR[7:0], clears pending and leaves high-next unchanged.
- R5: A peek (`hst_cs` with `hst_peek`) returns the same byte as a data read or status read would, and changes neither high-next nor pending.
- R6: In wide mode, a data write with high-next at 0 loads DR[7:0] and sets high-next. A data write with high-next at 1 loads DR[15:8] and clears high-next and pending.
- R7: In narrow mode, a data write loads DR[7:0], clears pending and leaves high-next unchanged.
- R8: `core_req_set` sets pending on the next clock. When it coincides with a host access that would clear pending, pending stays set.
- R9: Reset clears the data register, high-next, pending and narrow, so the port starts in wide mode.
- R10: `core_dr_we` loads the whole data register. `core_mode_we` loads narrow from `core_mode_narrow`. Each host strobe held for one cycle advances the byte sequence exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_cs | input | 1 | Host chip select |
| hst_rd | input | 1 | Host read strobe, one cycle |
| hst_wr | input | 1 | Host write strobe, one cycle |
| hst_peek | input | 1 | Host debug read, no side effects |
| hst_sel | input | 1 | Register select: 1 status, 0 data |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte, combinational |
| core_dr_we | input | 1 | Core load of the data register |
| core_dr_wdata | input | 16 | Core data word |
| core_req_set | input | 1 | Core raises the pending flag |
| core_mode_we | input | 1 | Core load of the width mode |
| core_mode_narrow | input | 1 | Width mode value, 1 = narrow |
| core_dr_rdata | output | 16 | Current data register |
| core_req_pend | output | 1 | Current pending flag |

## Verification
The hardest state to reach is a core request that lands in the same cycle as a host access that ends a transfer. In that case the host clear must lose while the byte-order flag still advances. The stimulus raises `core_req_set` on the same clock as a host data read, first on the low byte and then on the high byte. It then confirms through a status read that pending held while high-next wrapped back to 0. A second hard case is narrow mode entered while high-next is set. A wide low-byte read puts the sequencer half way through, the core then switches width, and the narrow read and write must leave high-next at 1.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
    localparam int BYTE_W_DEF = 8;
    // bit positions of the flags inside the host-visible status byte
    localparam int ST_PEND   = 7;
    localparam int ST_HI     = 6;
    localparam int ST_NARROW = 5;

    typedef struct packed {
        logic hi_next;
        logic pend;
        logic narrow;
    } flags_t;
endpackage

// File: rtl/hpi_seq.sv
module hpi_seq
    import hpi_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t flags_q_i,
    input  logic   rd_ev_i,
    input  logic   wr_ev_i,
    input  logic   peek_i,
    input  logic   core_set_i,
    input  logic   mode_we_i,
    input  logic   mode_narrow_i,
    output flags_t flags_d_o,
    output logic   lo_we_o,
    output logic   hi_we_o
);
    logic xfer_ev;
    logic clr_pend;

    always_comb begin
        flags_d_o = flags_q_i;
        xfer_ev   = rd_ev_i | wr_ev_i;
        clr_pend  = 1'b0;
        lo_we_o   = 1'b0;
        hi_we_o   = 1'b0;
        if (xfer_ev) begin
            if (flags_q_i.narrow) begin
                clr_pend = 1'b1;
                lo_we_o  = wr_ev_i;
            end else if (!flags_q_i.hi_next) begin
                flags_d_o.hi_next = 1'b1;
                lo_we_o           = wr_ev_i;
            end else begin
                flags_d_o.hi_next = 1'b0;
                clr_pend          = 1'b1;
                hi_we_o           = wr_ev_i;
            end
        end
        if (clr_pend)
            flags_d_o.pend = 1'b0;
        if (core_set_i)
            flags_d_o.pend = 1'b1;
        if (mode_we_i)
            flags_d_o.narrow = mode_narrow_i;
    end

    // a wide low-byte access must arm the high byte
    assert_wide_lo_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev_i && !flags_q_i.narrow && !flags_q_i.hi_next) |-> flags_d_o.hi_next);
    // the high-byte read closes the transfer unless the core re-raises it
    assert_wide_hi_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ev_i && !flags_q_i.narrow && flags_q_i.hi_next && !core_set_i)
        |-> (!flags_d_o.hi_next && !flags_d_o.pend));
    // narrow transfers never touch the byte-order flag
    assert_narrow_keeps_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ev && flags_q_i.narrow) |-> (flags_d_o.hi_next == flags_q_i.hi_next));
    // a peek alone moves no sequencing flag
    assert_peek_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i && !xfer_ev && !core_set_i)
        |-> (flags_d_o.hi_next == flags_q_i.hi_next && flags_d_o.pend == flags_q_i.pend));
    // the core request always wins over a host clear
    assert_core_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_set_i |-> flags_d_o.pend);
endmodule

// File: rtl/hpi_rmux.sv
module hpi_rmux
    import hpi_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int DR_W  = 2 * BYTE_W
)(
    input  logic              rd_act_i,
    input  logic              sel_i,
    input  flags_t            flags_i,
    input  logic [DR_W-1:0]   dr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    logic [BYTE_W-1:0] status_byte;
    logic              take_hi;

    always_comb begin
        status_byte            = '0;
        status_byte[ST_PEND]   = flags_i.pend;
        status_byte[ST_HI]     = flags_i.hi_next;
        status_byte[ST_NARROW] = flags_i.narrow;
        take_hi                = !flags_i.narrow && flags_i.hi_next;
        if (!rd_act_i)
            rdata_o = '0;
        else if (sel_i)
            rdata_o = status_byte;
        else if (take_hi)
            rdata_o = dr_i[DR_W-1:BYTE_W];
        else
            rdata_o = dr_i[BYTE_W-1:0];
    end

    // the read port is silent when no read is in progress
    always_comb begin
        if (!rd_act_i)
            assert_idle_bus_quiet_R1: assert (rdata_o == '0);
    end
endmodule

// File: rtl/hpi_byte_port.sv
module hpi_byte_port
    import hpi_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF,
    localparam int DR_W  = 2 * BYTE_W,
    localparam int LANES = DR_W / BYTE_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_cs,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic              hst_peek,
    input  logic              hst_sel,
    input  logic [BYTE_W-1:0] hst_wdata,
    output logic [BYTE_W-1:0] hst_rdata,
    input  logic              core_dr_we,
    input  logic [DR_W-1:0]   core_dr_wdata,
    input  logic              core_req_set,
    input  logic              core_mode_we,
    input  logic              core_mode_narrow,
    output logic [DR_W-1:0]   core_dr_rdata,
    output logic              core_req_pend
);
    typedef struct packed {
        logic [DR_W-1:0] dr;
        flags_t          flg;
    } state_t;

    state_t st_d, st_q;

    logic   rd_ev, wr_ev, peek_ev, rd_act;
    logic   lo_we, hi_we;
    flags_t flags_d;
    logic [LANES-1:0]  lane_we;
    logic [DR_W-1:0]   dr_host;

    // a read strobe wins over a write strobe in the same cycle
    assign rd_ev   = hst_cs && hst_rd && !hst_sel;
    assign wr_ev   = hst_cs && hst_wr && !hst_rd && !hst_sel;
    assign peek_ev = hst_cs && hst_peek && !hst_rd;
    assign rd_act  = hst_cs && (hst_rd || hst_peek);

    hpi_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .flags_q_i     (st_q.flg),
        .rd_ev_i       (rd_ev),
        .wr_ev_i       (wr_ev),
        .peek_i        (peek_ev),
        .core_set_i    (core_req_set),
        .mode_we_i     (core_mode_we),
        .mode_narrow_i (core_mode_narrow),
        .flags_d_o     (flags_d),
        .lo_we_o       (lo_we),
        .hi_we_o       (hi_we)
    );

    hpi_rmux #(.BYTE_W(BYTE_W)) u_rmux (
        .rd_act_i (rd_act),
        .sel_i    (hst_sel),
        .flags_i  (st_q.flg),
        .dr_i     (st_q.dr),
        .rdata_o  (hst_rdata)
    );

    assign lane_we = {hi_we, lo_we};

    // per-lane merge of the host byte into the data register
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dr_host[g*BYTE_W +: BYTE_W] =
            lane_we[g] ? hst_wdata : st_q.dr[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.flg = flags_d;
        st_d.dr  = core_dr_we ? core_dr_wdata : dr_host;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign core_dr_rdata = st_q.dr;
    assign core_req_pend = st_q.flg.pend;

    // status-location writes leave the data register alone
    assert_status_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_cs && hst_wr && hst_sel && !core_dr_we) |=> $stable(core_dr_rdata));
    // a status read moves no flag when the core is quiet
    assert_status_rd_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_cs && hst_rd && hst_sel && !core_req_set && !core_mode_we)
        |=> $stable(st_q.flg));
    // a wide high-byte write lands in the upper lane and ends the transfer
    assert_wide_hi_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && !st_q.flg.narrow && st_q.flg.hi_next && !core_dr_we && !core_req_set)
        |=> (core_dr_rdata[DR_W-1:BYTE_W] == $past(hst_wdata) && !core_req_pend));
    // a narrow write lands in the lower lane and clears pending
    assert_narrow_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && st_q.flg.narrow && !core_dr_we && !core_req_set)
        |=> (core_dr_rdata[BYTE_W-1:0] == $past(hst_wdata) && !core_req_pend));
    // the core request is visible one clock later
    assert_req_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        core_req_set |=> core_req_pend);
    // a core load replaces the whole word
    assert_core_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_dr_we |=> (core_dr_rdata == $past(core_dr_wdata)));
endmodule

// File: tb/sim_hpi_byte_port.sv
`timescale 1ns/1ps
module sim_hpi_byte_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_cs, hst_rd, hst_wr, hst_peek, hst_sel;
    logic [7:0]  hst_wdata, hst_rdata;
    logic        core_dr_we, core_req_set, core_mode_we, core_mode_narrow;
    logic [15:0] core_dr_wdata, core_dr_rdata;
    logic        core_req_pend;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hpi_byte_port u0 (
        .clk(clk), .rst_n(rst_n),
        .hst_cs(hst_cs), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_peek(hst_peek),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .core_dr_we(core_dr_we), .core_dr_wdata(core_dr_wdata),
        .core_req_set(core_req_set), .core_mode_we(core_mode_we),
        .core_mode_narrow(core_mode_narrow),
        .core_dr_rdata(core_dr_rdata), .core_req_pend(core_req_pend)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        hst_cs = 0; hst_rd = 0; hst_wr = 0; hst_peek = 0; hst_sel = 0;
        hst_wdata = 0; core_dr_we = 0; core_req_set = 0; core_mode_we = 0;
    endtask

    // one-cycle host access; returns the byte seen during the strobe
    task automatic host(input logic rd, input logic wr, input logic pk, input logic sel,
                        input logic [7:0] wd, input logic cset, output logic [7:0] got);
        @(negedge clk);
        hst_cs = 1; hst_rd = rd; hst_wr = wr; hst_peek = pk; hst_sel = sel;
        hst_wdata = wd; core_req_set = cset;
        #1 got = hst_rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic status_is(input string req, input logic [7:0] exp);
        logic [7:0] s;
        host(1, 0, 0, 1, 8'h00, 0, s);
        check(req, {8'h00, s}, {8'h00, exp});
    endtask

    task automatic core_load(input logic [15:0] w, input logic cset);
        @(negedge clk);
        core_dr_we = 1; core_dr_wdata = w; core_req_set = cset;
        @(negedge clk);
        idle();
    endtask

    task automatic core_mode(input logic nar);
        @(negedge clk);
        core_mode_we = 1; core_mode_narrow = nar;
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R9 data register after reset", core_dr_rdata, 16'h0000);
        status_is("R9 flags after reset", 8'h00);
        host(0, 0, 0, 0, 8'h00, 0, b);
        check("R1 bus idle", {8'h00, b}, 16'h0000);
    endtask

    task automatic t_wide_read();
        logic [7:0] b;
        core_load(16'hA55A, 1);
        check("R10 core load", core_dr_rdata, 16'hA55A);
        status_is("R8 request raised", 8'h80);
        status_is("R1 status read repeatable", 8'h80);
        host(1, 0, 0, 0, 8'h00, 0, b);
        check("R3 low byte first", {8'h00, b}, 16'h005A);
        status_is("R3 high-next set", 8'hC0);
        host(1, 0, 0, 0, 8'h00, 0, b);
        check("R3 high byte second", {8'h00, b}, 16'h00A5);
        status_is("R3 transfer closed", 8'h00);
        check("R10 pending port", {15'd0, core_req_pend}, 16'h0000);
    endtask

    task automatic t_peek();
        logic [7:0] b;
        core_load(16'h1234, 1);
        host(0, 0, 1, 0, 8'h00, 0, b);
        check("R5 peek low", {8'h00, b}, 16'h0034);
        status_is("R5 peek kept flags", 8'h80);
        host(1, 0, 0, 0, 8'h00, 0, b);
        check("R3 read after peek", {8'h00, b}, 16'h0034);
        host(0, 0, 1, 0, 8'h00, 0, b);
        check("R5 peek high", {8'h00, b}, 16'h0012);
        host(0, 0, 1, 1, 8'h00, 0, b);
        check("R5 peek status", {8'h00, b}, 16'h00C0);
        host(1, 0, 0, 0, 8'h00, 0, b);
        check("R3 high read after peek", {8'h00, b}, 16'h0012);
        status_is("R5 R3 closed", 8'h00);
    endtask

    task automatic t_wide_write();
        logic [7:0] b;
        core_load(16'h0000, 1);
        host(0, 1, 0, 0, 8'h11, 0, b);
        status_is("R6 low write arms high", 8'hC0);
        check("R6 low lane", core_dr_rdata, 16'h0011);
        host(0, 1, 0, 0, 8'h22, 0, b);
        status_is("R6 high write closes", 8'h00);
        check("R6 word assembled", core_dr_rdata, 16'h2211);
    endtask

    task automatic t_status_write();
        logic [7:0] b;
        host(0, 1, 0, 1, 8'hFF, 0, b);
        check("R2 data untouched", core_dr_rdata, 16'h2211);
        status_is("R2 flags untouched", 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] b;
        host(1, 0, 0, 0, 8'h00, 1, b);
        check("R8 low read with request", {8'h00, b}, 16'h0011);
        status_is("R8 pending and high-next", 8'hC0);
        host(1, 0, 0, 0, 8'h00, 1, b);
        check("R8 high read with request", {8'h00, b}, 16'h0022);
        status_is("R8 request wins clear", 8'h80);
    endtask

    task automatic t_narrow();
        logic [7:0] b;
        host(1, 0, 0, 0, 8'h00, 0, b);
        status_is("R3 half way", 8'hC0);
        core_mode(1);
        status_is("R10 narrow mode", 8'hE0);
        host(1, 0, 0, 0, 8'h00, 0, b);
        check("R4 narrow read low", {8'h00, b}, 16'h0011);
        status_is("R4 pending cleared order kept", 8'h60);
        core_load(16'h2211, 1);
        host(0, 1, 0, 0, 8'h77, 0, b);
        check("R7 narrow write low lane", core_dr_rdata, 16'h2277);
        status_is("R7 pending cleared order kept", 8'h60);
    endtask

    initial begin
        idle();
        core_mode_narrow = 0;
        core_dr_wdata = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_wide_read();
        t_peek();
        t_wide_write();
        t_status_write();
        t_collision();
        t_narrow();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule